// File: doc/BRIEF.md
# Two-Source Interrupt Level Encoder with Acknowledge Routing

This block sits between two peripheral interrupt controllers and a CPU that takes an active-low 3-bit interrupt priority input. Each peripheral raises one active-low request line. The block synchronises both lines and folds them into a single priority level. It then drives that level to the CPU in inverted form.

When the CPU grants an interrupt, it runs an acknowledge bus cycle. The CPU marks that cycle with an all-ones function code and an asserted address strobe. It places the acknowledged level on address bits 3 to 1. The block decodes that cycle and drives a separate active-low acknowledge to the peripheral that owns the level. The acknowledge lasts as long as the strobe stays asserted. The peripheral can then present its vector on the bus. Supplying the vector itself is outside this block.

Top module: `irq_merge_top`

## Requirements
- R1: Each request input passes through two synchroniser flops and then an output register. A change driven before clock edge k first appears on `ipl_n` after edge k+2, and `ipl_n` still shows the old value after edge k+1.
- R2: When only `irq_a_n` is low, `ipl_n` is the bitwise inverse of level 6, which is 3'b001.
- R3: When only `irq_b_n` is low, `ipl_n` is the bitwise inverse of level 5, which is 3'b010.
- R4: When both requests are low, the higher level wins and `ipl_n` is 3'b001.
- R5: When neither request is low, `ipl_n` is 3'b111.
- R6: An acknowledge cycle means `fc` == 3'b111 and `as_n` low. If the edge samples such a cycle with `addr_lvl` == 6, `ack_a_n` is low after that edge, and `ack_b_n` stays high.
- R7: If the edge samples an acknowledge cycle with `addr_lvl` == 5, `ack_b_n` is low after that edge, and `ack_a_n` stays high.
- R8: An acknowledge stays low for every edge that samples `as_n` low with the same cycle inputs. It returns high after the first edge that samples `as_n` high.
- R9: Both acknowledges stay high in two cases: when `fc` is not 3'b111, and when `addr_lvl` is neither 6 nor 5.
- R10: While `rst_n` is low, `ipl_n` is 3'b111 and both acknowledges are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| irq_a_n | input | 1 | Active-low request from peripheral A (level 6) |
| irq_b_n | input | 1 | Active-low request from peripheral B (level 5) |
| ipl_n | output | 3 | Inverted interrupt priority level to the CPU |
| fc | input | 3 | CPU function code |
| as_n | input | 1 | CPU address strobe, active low |
| addr_lvl | input | 3 | CPU address bits 3 to 1, carrying the acknowledged level |
| ack_a_n | output | 1 | Active-low acknowledge to peripheral A |
| ack_b_n | output | 1 | Active-low acknowledge to peripheral B |

## Verification
The acknowledge assertions assume two things about the CPU side: `fc`, `addr_lvl` and `as_n` are synchronous to `clk`, and they hold steady for the whole of a strobe. The bench drives these inputs only on falling edges and keeps them fixed while the strobe is low. For each function code and level pair it drives one complete strobe, and it releases the strobe before it changes the code. The request lines are treated as asynchronous. The bench still changes them only on falling edges, so the three-edge latency can be sampled at an exact cycle.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
    localparam int IPL_W = 3;
    localparam int FC_W  = 3;
    localparam logic [FC_W-1:0] FC_IACK = 3'b111;

    typedef struct packed {
        logic [IPL_W-1:0] ipl_n;
    } prio_st_t;

    typedef struct packed {
        logic ack_a_n;
        logic ack_b_n;
    } ack_st_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int N_SRC  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] async_n,
    output logic [N_SRC-1:0] sync_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][N_SRC-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = async_n;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q[g] <= '1;
                else        sh_q[g] <= sh_d[g];
            end
        end
    endgenerate

    assign sync_n = sh_q[LAST];
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_merge_pkg::*;
#(
    parameter int LEVEL_A = 6,
    parameter int LEVEL_B = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_n,
    output logic [IPL_W-1:0] ipl_n
);
    localparam logic [IPL_W-1:0] LVL_A = IPL_W'(LEVEL_A);
    localparam logic [IPL_W-1:0] LVL_B = IPL_W'(LEVEL_B);

    prio_st_t st_d, st_q;
    logic [IPL_W-1:0] lvl_a, lvl_b, lvl_win;

    always_comb begin
        lvl_a   = req_n[0] ? '0 : LVL_A;
        lvl_b   = req_n[1] ? '0 : LVL_B;
        lvl_win = (lvl_a >= lvl_b) ? lvl_a : lvl_b;
        st_d    = st_q;
        st_d.ipl_n = ~lvl_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ipl_n: '1};
        else        st_q <= st_d;
    end

    assign ipl_n = st_q.ipl_n;

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n == 2'b11) |=> (ipl_n == 3'b111));
    // R2
    a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n[0] && (LEVEL_A >= LEVEL_B)) |=> (ipl_n == ~LVL_A));
    // R3
    b_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n == 2'b01) |=> (ipl_n == ~LVL_B));
endmodule

// File: rtl/irq_ack.sv
module irq_ack
    import irq_merge_pkg::*;
#(
    parameter int LEVEL_A = 6,
    parameter int LEVEL_B = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FC_W-1:0]  fc,
    input  logic             as_n,
    input  logic [IPL_W-1:0] addr_lvl,
    output logic             ack_a_n,
    output logic             ack_b_n
);
    localparam logic [IPL_W-1:0] LVL_A = IPL_W'(LEVEL_A);
    localparam logic [IPL_W-1:0] LVL_B = IPL_W'(LEVEL_B);

    ack_st_t st_d, st_q;
    logic    iack_cyc;

    always_comb begin
        iack_cyc     = (fc == FC_IACK) && !as_n;
        st_d         = st_q;
        st_d.ack_a_n = !(iack_cyc && (addr_lvl == LVL_A));
        st_d.ack_b_n = !(iack_cyc && (addr_lvl == LVL_B));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ack_a_n: 1'b1, ack_b_n: 1'b1};
        else        st_q <= st_d;
    end

    assign ack_a_n = st_q.ack_a_n;
    assign ack_b_n = st_q.ack_b_n;

    // R6
    ack_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_a_n |-> $past(fc == FC_IACK && !as_n && addr_lvl == LVL_A));
    // R7
    ack_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_b_n |-> $past(fc == FC_IACK && !as_n && addr_lvl == LVL_B));
    // R8
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (ack_a_n && ack_b_n));
    // R9
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ack_a_n, !ack_b_n}));
endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top
    import irq_merge_pkg::*;
#(
    parameter int LEVEL_A     = 6,
    parameter int LEVEL_B     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_a_n,
    input  logic             irq_b_n,
    output logic [IPL_W-1:0] ipl_n,
    input  logic [FC_W-1:0]  fc,
    input  logic             as_n,
    input  logic [IPL_W-1:0] addr_lvl,
    output logic             ack_a_n,
    output logic             ack_b_n
);
    logic [1:0] req_sync_n;

    irq_sync #(.N_SRC(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n ({irq_b_n, irq_a_n}),
        .sync_n  (req_sync_n)
    );

    irq_prio #(.LEVEL_A(LEVEL_A), .LEVEL_B(LEVEL_B)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_sync_n),
        .ipl_n (ipl_n)
    );

    irq_ack #(.LEVEL_A(LEVEL_A), .LEVEL_B(LEVEL_B)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc       (fc),
        .as_n     (as_n),
        .addr_lvl (addr_lvl),
        .ack_a_n  (ack_a_n),
        .ack_b_n  (ack_b_n)
    );
endmodule

// File: tb/tb_irq_merge_top.sv
`timescale 1ns/1ps
module tb_irq_merge_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       irq_a_n, irq_b_n, as_n;
    logic [2:0] fc, addr_lvl, ipl_n;
    logic       ack_a_n, ack_b_n;
    int         n_chk = 0, n_fail = 0;
    logic [2:0] prev_ipl;

    always #10 clk = ~clk;

    irq_merge_top dut (
        .clk(clk), .rst_n(rst_n), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
        .ipl_n(ipl_n), .fc(fc), .as_n(as_n), .addr_lvl(addr_lvl),
        .ack_a_n(ack_a_n), .ack_b_n(ack_b_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ipl(input logic a_n, input logic b_n);
        int la, lb, m;
        la = a_n ? 0 : 6;
        lb = b_n ? 0 : 5;
        m  = (la > lb) ? la : lb;
        return ~3'(m);
    endfunction

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_a_n = 1'b1; irq_b_n = 1'b1;
        as_n = 1'b1; fc = 3'b000; addr_lvl = 3'd0;
        // R10: drive requests and a valid acknowledge cycle during reset
        edges(2);
        irq_a_n = 1'b0; as_n = 1'b0; fc = 3'b111; addr_lvl = 3'd6;
        edges(4);
        check("R10 ipl_n", ipl_n, 7);
        check("R10 ack_a_n", ack_a_n, 1);
        check("R10 ack_b_n", ack_b_n, 1);
        irq_a_n = 1'b1; as_n = 1'b1; fc = 3'b000;
        rst_n = 1'b1;
        edges(4);
        check("R5 idle ipl_n", ipl_n, 7);

        // R1..R5: every transition among the four request combinations
        prev_ipl = ipl_n;
        for (int from = 0; from < 4; from++) begin
            for (int to = 0; to < 4; to++) begin
                irq_a_n = from[0]; irq_b_n = from[1];
                edges(4);
                prev_ipl = exp_ipl(from[0], from[1]);
                irq_a_n = to[0]; irq_b_n = to[1];
                edges(2);
                check("R1 ipl_n before latency", ipl_n, prev_ipl);
                edges(1);
                check((to == 2) ? "R2 ipl_n" : (to == 1) ? "R3 ipl_n" :
                      (to == 0) ? "R4 ipl_n" : "R5 ipl_n",
                      ipl_n, exp_ipl(to[0], to[1]));
            end
        end
        irq_a_n = 1'b1; irq_b_n = 1'b1;

        // R6..R9: every function code against every level
        for (int f = 0; f < 8; f++) begin
            for (int l = 0; l < 8; l++) begin
                int ea, eb;
                ea = (f == 7 && l == 6) ? 0 : 1;
                eb = (f == 7 && l == 5) ? 0 : 1;
                fc = 3'(f); addr_lvl = 3'(l); as_n = 1'b0;
                edges(1);
                check((ea == 0) ? "R6 ack_a_n" : "R9 ack_a_n", ack_a_n, ea);
                check((eb == 0) ? "R7 ack_b_n" : "R9 ack_b_n", ack_b_n, eb);
                edges(2);
                check("R8 ack_a_n held", ack_a_n, ea);
                check("R8 ack_b_n held", ack_b_n, eb);
                as_n = 1'b1;
                edges(1);
                check("R8 ack_a_n release", ack_a_n, 1);
                check("R8 ack_b_n release", ack_b_n, 1);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule